// File: doc/BRIEF.md
# Serial Flash Command Frame Host

This block is a register-programmed SPI host for serial flash parts. Software loads an instruction value, an address value, a header byte count and a read byte count, asserts chip select through the control register, and then starts a frame. A frame shifts out the header bytes, instruction first and address second, and then runs a data phase. In the write direction the data phase drains bytes that software has pushed into a transmit FIFO. In the read direction it clocks bytes from the flash into a receive FIFO, which software empties one byte per read of the data-in register.

Frames end through handshake bits that clear themselves. A read with a nonzero count finishes by itself after exactly that many bytes. A read with a zero count runs until software requests stop, which suits status polling. A write frame ends when stop is requested, the shifter is idle and the transmit FIFO is empty. The host interface is a plain word-wide register bus with no wait states. Read data is combinational from the address, and a read of the data-in offset pops the receive FIFO on the same clock edge. The SPI side uses one data line in mode 0, with SCLK set by a fixed divider parameter.

Top module: `sflash_host`

## Requirements
- R1: After reset, SCLK is low, chip select is high, the configuration register reads 0, and the control register reads 0x52: transfer-ready set, both FIFOs empty, transmit-full clear.
- R2: The chip-select pin takes the value of control bit 0, inverted, one clock after the write. Transfer-ready (control bit 1) is low in the cycle between the write and the pin change, and high again once the pin agrees.
- R3: A frame first sends the number of instruction bytes in header-count bits 3:0, then the number of address bytes in bits 7:4. Header byte k of n comes from byte n-1-k of the instruction register (offset 0x10) or of the address register (offset 0x14), so the bytes go out most significant first. Byte positions at or above 4 are sent as zero.
- R4: Bits go out MSB first in mode 0. SCLK rests low. MOSI holds steady while SCLK is high. Each SCLK phase lasts DIV clocks.
- R5: With configuration bit 13 set (write direction) and bit 15 (start) written to 1, the data phase sends the bytes pushed to data-out (offset 0x08) in the order they were pushed. A stop request (bit 14, accepted only while start is set) ends the frame once the transmit FIFO is empty and the shifter is idle. Start and stop then read back as 0.
- R6: In the read direction (bit 13 clear) with a nonzero read count (offset 0x20), exactly that many bytes are clocked after the header and captured in the order received. Start then clears without a stop request.
- R7: A read count of zero makes the read phase continue byte after byte until stop is requested. The byte in flight then completes, and start clears.
- R8: In a read phase, no new byte is started while the 8-entry receive FIFO is full, and SCLK stays low until a byte is popped.
- R9: Writing configuration bit 9 empties both FIFOs. The bit reads 1 in the cycle after the write and 0 afterwards.
- R10: A write to data-out while the transmit FIFO holds 8 bytes is ignored and stores nothing.
- R11: A read of data-in (offset 0x0C) returns the oldest received byte in bits 7:0 and pops it. With the receive FIFO empty, it returns the byte popped last and leaves the FIFO state unchanged.
- R12: The control register reports receive-empty in bit 4, transmit-empty in bit 6 and transmit-full in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at offset 0x0C) |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock, low when idle |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The properties assume that software never writes the flush bit in two consecutive cycles. They also assume that the header, address, count and direction registers stay unchanged while start reads 1, and that stop is requested only after start has been set. The bench holds to these rules. Every frame is programmed before start is written, and the bench polls start back to 0 before it reprograms anything. Flush is only ever a single write, and stop is written as a read-modify-write that keeps start and direction.

// File: rtl/sfh_pkg.sv
package sfh_pkg;
  localparam int BUS_AW = 6;

  localparam logic [BUS_AW-1:0] OFS_CTRL = 6'h00;
  localparam logic [BUS_AW-1:0] OFS_CONF = 6'h04;
  localparam logic [BUS_AW-1:0] OFS_TXD  = 6'h08;
  localparam logic [BUS_AW-1:0] OFS_RXD  = 6'h0C;
  localparam logic [BUS_AW-1:0] OFS_INS  = 6'h10;
  localparam logic [BUS_AW-1:0] OFS_ADR  = 6'h14;
  localparam logic [BUS_AW-1:0] OFS_HDR  = 6'h1C;
  localparam logic [BUS_AW-1:0] OFS_RCNT = 6'h20;

  // control register bits
  localparam int B_CS     = 0;
  localparam int B_RDY    = 1;
  localparam int B_RXE    = 4;
  localparam int B_TXE    = 6;
  localparam int B_TXF    = 7;
  // configuration register bits
  localparam int B_FLUSH  = 9;
  localparam int B_WID    = 10;
  localparam int B_DIR    = 13;
  localparam int B_STOP   = 14;
  localparam int B_START  = 15;

  typedef enum logic [2:0] {
    PH_IDLE, PH_HDR, PH_WR, PH_RD, PH_END
  } phase_e;
endpackage

// File: rtl/sfh_fifo.sv
module sfh_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  // DEPTH is expected to be a power of two so pointers wrap naturally
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sfh_shifter.sv
module sfh_shifter #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] txb,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rxb,
  output logic       sclk,
  output logic       mosi
);
  localparam int DW = (DIV < 2) ? 1 : $clog2(DIV);

  logic [DW-1:0] dcnt;
  logic [2:0]    bcnt;
  logic [7:0]    sh, rx;

  assign mosi = sh[7];
  assign rxb  = rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      sclk <= 1'b0;
      dcnt <= '0;
      bcnt <= '0;
      sh   <= '0;
      rx   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          sh   <= txb;
          dcnt <= '0;
          bcnt <= '0;
        end
      end else if (dcnt == DW'(DIV-1)) begin
        dcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bcnt == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfh_engine.sv
module sfh_engine import sfh_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             dir_wr,
  input  logic [3:0]       ins_n,
  input  logic [3:0]       adr_n,
  input  logic [31:0]      ins_reg,
  input  logic [31:0]      adr_reg,
  input  logic [CNT_W-1:0] rcnt,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  input  logic             rx_full,
  input  logic             sh_busy,
  input  logic             sh_done,
  output logic             sh_go,
  output logic [7:0]       sh_tx,
  output logic             tx_pop,
  output logic             rx_push,
  output logic             frame_end,
  output logic             rd_phase
);
  phase_e           ph, ph_n;
  logic [4:0]       hidx, hidx_n;
  logic [CNT_W-1:0] left, left_n;
  logic             endless, endless_n;
  logic [4:0]       hdr_total, aoff;
  logic [3:0]       sel;
  logic [7:0]       hbyte;
  logic             idle_ok;

  function automatic logic [7:0] pick(input logic [31:0] r, input logic [3:0] s);
    if (s < 4'd4) return r[{s[1:0], 3'b000} +: 8];
    return 8'h00;
  endfunction

  assign hdr_total = {1'b0, ins_n} + {1'b0, adr_n};
  assign aoff      = hidx - {1'b0, ins_n};
  assign idle_ok   = !sh_busy && !sh_done;
  assign rd_phase  = (ph == PH_RD);
  assign rx_push   = sh_done && (ph == PH_RD);

  always_comb begin
    if (hidx < {1'b0, ins_n}) begin
      sel   = ins_n - 4'd1 - hidx[3:0];
      hbyte = pick(ins_reg, sel);
    end else begin
      sel   = adr_n - 4'd1 - aoff[3:0];
      hbyte = pick(adr_reg, sel);
    end
  end

  always_comb begin
    ph_n      = ph;
    hidx_n    = hidx;
    left_n    = left;
    endless_n = endless;
    sh_go     = 1'b0;
    sh_tx     = 8'h00;
    tx_pop    = 1'b0;
    frame_end = 1'b0;
    case (ph)
      PH_IDLE: if (start) begin
        ph_n      = PH_HDR;
        hidx_n    = '0;
        left_n    = rcnt;
        endless_n = (rcnt == '0);
      end
      PH_HDR: if (idle_ok) begin
        if (hidx == hdr_total) begin
          ph_n = dir_wr ? PH_WR : PH_RD;
        end else begin
          sh_go  = 1'b1;
          sh_tx  = hbyte;
          hidx_n = hidx + 1'b1;
        end
      end
      PH_WR: if (idle_ok) begin
        if (!tx_empty) begin
          sh_go  = 1'b1;
          sh_tx  = tx_data;
          tx_pop = 1'b1;
        end else if (stop) begin
          ph_n = PH_END;
        end
      end
      PH_RD: if (idle_ok) begin
        if (stop || (!endless && left == '0)) begin
          ph_n = PH_END;
        end else if (!rx_full) begin
          sh_go = 1'b1;
          if (!endless) left_n = left - 1'b1;
        end
      end
      PH_END: begin
        frame_end = 1'b1;
        ph_n      = PH_IDLE;
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      hidx    <= '0;
      left    <= '0;
      endless <= 1'b0;
    end else begin
      ph      <= ph_n;
      hidx    <= hidx_n;
      left    <= left_n;
      endless <= endless_n;
    end
  end
endmodule

// File: rtl/sflash_host.sv
module sflash_host import sfh_pkg::*; #(
  parameter int DIV        = 2,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic             cs_en, cs_n_q, dir_wr, start_q, stop_q, flush_q;
  logic [2:0]       width;
  logic [31:0]      ins_reg, adr_reg;
  logic [7:0]       hdr_reg, rx_last;
  logic [CNT_W-1:0] rcnt_reg;
  logic             wr_ctrl, wr_conf, wr_txd, rd_rxd;
  logic             tx_empty, tx_full, tx_pop, rx_empty, rx_full, rx_push, rx_pop;
  logic [7:0]       tx_head, rx_head, sh_tx, sh_rx;
  logic             sh_go, sh_busy, sh_done, frame_end, rd_phase, xfer_rdy;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_conf  = bus_wr && (bus_addr == OFS_CONF);
  assign wr_txd   = bus_wr && (bus_addr == OFS_TXD);
  assign rd_rxd   = bus_rd && (bus_addr == OFS_RXD);
  assign rx_pop   = rd_rxd && !rx_empty;
  assign spi_cs_n = cs_n_q;
  assign xfer_rdy = (cs_n_q == ~cs_en) && !sh_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en    <= 1'b0;
      cs_n_q   <= 1'b1;
      dir_wr   <= 1'b0;
      width    <= '0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      flush_q  <= 1'b0;
      ins_reg  <= '0;
      adr_reg  <= '0;
      hdr_reg  <= '0;
      rcnt_reg <= '0;
      rx_last  <= '0;
    end else begin
      cs_n_q  <= ~cs_en;
      flush_q <= wr_conf && bus_wdata[B_FLUSH];
      if (wr_ctrl) cs_en <= bus_wdata[B_CS];
      if (wr_conf) begin
        width  <= bus_wdata[B_WID +: 3];
        dir_wr <= bus_wdata[B_DIR];
      end
      if (frame_end)                             start_q <= 1'b0;
      else if (wr_conf && bus_wdata[B_START])    start_q <= 1'b1;
      if (frame_end)                             stop_q  <= 1'b0;
      else if (wr_conf && bus_wdata[B_STOP] && start_q) stop_q <= 1'b1;
      if (bus_wr && bus_addr == OFS_INS)  ins_reg  <= bus_wdata;
      if (bus_wr && bus_addr == OFS_ADR)  adr_reg  <= bus_wdata;
      if (bus_wr && bus_addr == OFS_HDR)  hdr_reg  <= bus_wdata[7:0];
      if (bus_wr && bus_addr == OFS_RCNT) rcnt_reg <= bus_wdata[CNT_W-1:0];
      if (rx_pop) rx_last <= rx_head;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[B_CS]  = cs_en;
        bus_rdata[B_RDY] = xfer_rdy;
        bus_rdata[B_RXE] = rx_empty;
        bus_rdata[B_TXE] = tx_empty;
        bus_rdata[B_TXF] = tx_full;
      end
      OFS_CONF: begin
        bus_rdata[B_FLUSH]     = flush_q;
        bus_rdata[B_WID +: 3]  = width;
        bus_rdata[B_DIR]       = dir_wr;
        bus_rdata[B_STOP]      = stop_q;
        bus_rdata[B_START]     = start_q;
      end
      OFS_RXD:  bus_rdata[7:0] = rx_empty ? rx_last : rx_head;
      OFS_INS:  bus_rdata = ins_reg;
      OFS_ADR:  bus_rdata = adr_reg;
      OFS_HDR:  bus_rdata[7:0] = hdr_reg;
      OFS_RCNT: bus_rdata[CNT_W-1:0] = rcnt_reg;
      default:  bus_rdata = '0;
    endcase
  end

  sfh_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush_q),
    .push(wr_txd), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
  );

  sfh_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_q),
    .push(rx_push), .wdata(sh_rx),
    .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
  );

  sfh_shifter #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .txb(sh_tx), .miso(spi_miso),
    .busy(sh_busy), .done(sh_done), .rxb(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi)
  );

  sfh_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_q), .stop(stop_q), .dir_wr(dir_wr),
    .ins_n(hdr_reg[3:0]), .adr_n(hdr_reg[7:4]), .ins_reg(ins_reg), .adr_reg(adr_reg),
    .rcnt(rcnt_reg), .tx_empty(tx_empty), .tx_data(tx_head), .rx_full(rx_full),
    .sh_busy(sh_busy), .sh_done(sh_done), .sh_go(sh_go), .sh_tx(sh_tx),
    .tx_pop(tx_pop), .rx_push(rx_push), .frame_end(frame_end), .rd_phase(rd_phase)
  );
endmodule

// File: rtl/sfh_checker.sv
module sfh_checker (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic cs_en,
  input logic flush_q,
  input logic rx_full,
  input logic sh_busy,
  input logic rd_phase,
  input logic tx_full,
  input logic tx_pop
);
  assert_cs_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n == !$past(cs_en));

  assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_sclk_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> !spi_sclk);

  assert_hold_on_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && rx_full && !sh_busy) |=> !spi_sclk);

  assert_flush_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_pop && !flush_q) |=> tx_full);
endmodule

bind sflash_host sfh_checker u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .cs_en(cs_en), .flush_q(flush_q), .rx_full(rx_full),
  .sh_busy(sh_busy), .rd_phase(rd_phase), .tx_full(tx_full), .tx_pop(tx_pop)
);

// File: tb/tb_sflash_host.sv
module tb_sflash_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int n_chk = 0, n_err = 0;
  int medge = 0;
  logic [7:0] mlog [256];
  logic [31:0] rv;
  logic [7:0] last_rx;

  localparam logic [31:0] INS_V = 32'hC1D2E3F4;
  localparam logic [31:0] ADR_V = 32'h5A6B7C8D;

  always #2 clk = ~clk;

  sflash_host dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 29 + 90);
  endfunction

  function automatic logic [7:0] hdr_byte(input int k, input int ni, input int na);
    int s;
    logic [31:0] r;
    if (k < ni) begin s = ni - 1 - k; r = INS_V; end
    else begin s = na - 1 - (k - ni); r = ADR_V; end
    if (s < 4) return r[8*s +: 8];
    return 8'h00;
  endfunction

  // flash model: logs MOSI and answers on MISO, one byte per 8 rising edges
  always @(posedge spi_sclk) begin
    mlog[(medge/8) % 256] = {mlog[(medge/8) % 256][6:0], spi_mosi};
    medge = medge + 1;
  end

  always @(medge) begin
    logic [7:0] b;
    b = resp(medge / 8);
    spi_miso = b[7 - (medge % 8)];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_start_clear(input string tag);
    logic [31:0] v;
    int guard = 0;
    do begin
      rd(6'h04, v);
      guard++;
    end while (v[15] && guard < 4000);
    chk(tag, 32'(v[15]), 32'd0);
  endtask

  task automatic stop_frame(input logic dirw);
    logic [31:0] v;
    int guard = 0;
    do begin
      rd(6'h00, v);
      guard++;
    end while (!(v[1] && v[6]) && guard < 4000);
    wr(6'h04, (32'(dirw) << 13) | 32'h0000_C000);
  endtask

  task automatic run_write(input int ni, input int na, input int nd, input int tag_base);
    wr(6'h04, 32'h200);
    wr(6'h1C, 32'((na << 4) | ni));
    for (int j = 0; j < nd; j++) wr(6'h08, 32'(8'(8'h40 + j * 13 + tag_base)));
    @(negedge clk); medge = 0;
    wr(6'h04, 32'h0000_A000);
    stop_frame(1'b1);
    wait_start_clear("R5 start clears after stop");
    chk("R3 edge count", 32'(medge), 32'(8 * (ni + na + nd)));
    for (int k = 0; k < ni + na; k++)
      chk("R3 header byte", 32'(mlog[k]), 32'(hdr_byte(k, ni, na)));
    for (int j = 0; j < nd; j++)
      chk("R5 data byte", 32'(mlog[ni + na + j]), 32'(8'(8'h40 + j * 13 + tag_base)));
  endtask

  task automatic pop_wait(output logic [7:0] b);
    logic [31:0] v;
    int guard = 0;
    do begin
      rd(6'h00, v);
      guard++;
    end while (v[4] && guard < 4000);
    rd(6'h0C, v);
    b = v[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk", 32'(spi_sclk), 0);
    chk("R1 cs_n", 32'(spi_cs_n), 1);
    rd(6'h00, rv); chk("R1 ctrl", rv, 32'h52);
    rd(6'h04, rv); chk("R1 conf", rv, 32'h0);

    // R2 chip select handshake
    wr(6'h00, 32'h1);
    bus_addr = 6'h00; #1;
    chk("R2 rdy low before select lands", 32'(bus_rdata[1]), 0);
    chk("R2 cs_n not yet", 32'(spi_cs_n), 1);
    @(negedge clk); #1;
    chk("R2 rdy high", 32'(bus_rdata[1]), 1);
    chk("R2 cs_n asserted", 32'(spi_cs_n), 0);

    wr(6'h10, INS_V);
    wr(6'h14, ADR_V);

    // R3 R5 sweep over header shapes and write data lengths
    for (int ni = 0; ni <= 2; ni++)
      for (int na = 0; na <= 4; na++)
        for (int nd = 0; nd <= 2; nd++)
          run_write(ni, na, nd, ni * 16 + na * 4 + nd);
    // header positions at or above 4 send zero
    run_write(1, 5, 1, 7);

    // R6 fixed-count reads, header 1+3
    for (int n = 1; n <= 9; n++) begin
      wr(6'h04, 32'h200);
      wr(6'h1C, 32'h31);
      wr(6'h20, 32'(n));
      @(negedge clk); medge = 0;
      wr(6'h04, 32'h8000);
      for (int j = 0; j < n; j++) begin
        logic [7:0] b;
        pop_wait(b);
        chk("R6 read byte", 32'(b), 32'(resp(4 + j)));
        last_rx = b;
      end
      wait_start_clear("R6 start self clears");
      chk("R6 exact edges", 32'(medge), 32'(8 * (4 + n)));
      rd(6'h00, rv); chk("R12 rx empty after read", 32'(rv[4]), 1);
    end

    // R8 back-pressure with a full receive FIFO
    wr(6'h04, 32'h200);
    wr(6'h1C, 32'h01);
    wr(6'h20, 32'd11);
    @(negedge clk); medge = 0;
    wr(6'h04, 32'h8000);
    repeat (1500) @(negedge clk);
    chk("R8 clock held when full", 32'(medge), 32'(8 * 9));
    rd(6'h04, rv); chk("R8 frame still open", 32'(rv[15]), 1);
    for (int j = 0; j < 11; j++) begin
      logic [7:0] b;
      pop_wait(b);
      chk("R8 byte after hold", 32'(b), 32'(resp(1 + j)));
    end
    wait_start_clear("R8 frame completes");
    chk("R8 total edges", 32'(medge), 32'(8 * 12));

    // R7 endless read stopped by software
    wr(6'h04, 32'h200);
    wr(6'h1C, 32'h01);
    wr(6'h20, 32'd0);
    @(negedge clk); medge = 0;
    wr(6'h04, 32'h8000);
    for (int j = 0; j < 5; j++) begin
      logic [7:0] b;
      pop_wait(b);
      chk("R7 status byte", 32'(b), 32'(resp(1 + j)));
      last_rx = b;
    end
    wr(6'h04, 32'h0000_C000);
    wait_start_clear("R7 stop ends endless read");
    chk("R7 whole bytes", 32'(medge % 8), 0);
    chk("R7 ran past five bytes", 32'(medge >= 48), 1);

    // R9 flush empties both FIFOs, bit self clears
    wr(6'h08, 32'h11); wr(6'h08, 32'h22); wr(6'h08, 32'h33);
    rd(6'h00, rv); chk("R12 tx not empty", 32'(rv[6]), 0);
    wr(6'h04, 32'h200);
    bus_addr = 6'h04; #1;
    chk("R9 flush bit visible", 32'(bus_rdata[9]), 1);
    rd(6'h04, rv); chk("R9 flush bit cleared", 32'(rv[9]), 0);
    rd(6'h00, rv);
    chk("R9 tx empty", 32'(rv[6]), 1);
    chk("R9 rx empty", 32'(rv[4]), 1);

    // R11 empty read returns last popped value
    rd(6'h0C, rv); chk("R11 empty read last", rv, 32'(last_rx));
    rd(6'h0C, rv); chk("R11 empty read again", rv, 32'(last_rx));
    rd(6'h00, rv); chk("R11 still empty", 32'(rv[4]), 1);

    // R10 R12 transmit full, ninth write ignored
    for (int j = 0; j < 9; j++) wr(6'h08, 32'(8'h80 + j));
    rd(6'h00, rv);
    chk("R12 tx full bit", 32'(rv[7]), 1);
    chk("R12 tx empty bit", 32'(rv[6]), 0);
    wr(6'h1C, 32'h00);
    @(negedge clk); medge = 0;
    wr(6'h04, 32'h0000_A000);
    stop_frame(1'b1);
    wait_start_clear("R10 frame ends");
    chk("R10 only eight bytes sent", 32'(medge), 64);
    for (int j = 0; j < 8; j++)
      chk("R10 byte order", 32'(mlog[j]), 32'(8'h80 + j));

    // R2 deselect
    wr(6'h00, 32'h0);
    @(negedge clk);
    chk("R2 cs_n released", 32'(spi_cs_n), 1);
    rd(6'h00, rv); chk("R2 rdy after release", 32'(rv[1]), 1);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule